// File: doc/BRIEF.md
# Link Pause Transmit Gate

This block stops a MAC transmitter from pulling new frames out of its transmit FIFO while the link partner has asked for a link-level pause. A pause request arrives as a one-cycle strobe with a 16-bit quanta value. The block keeps that value in a countdown timer. If a frame is still going out, the block lets it finish first. After that it closes the read gate of the transmit FIFO and counts the timer down, one step per quanta tick. When the count runs out, the gate opens again.

The status output reports whether the transmitter is actually paused. It does not report whether a pause frame has arrived. It can therefore rise several cycles after the request, once the ongoing frame has ended. A later request with a non-zero quanta reloads the timer. A request with quanta zero withdraws a pause that is pending or running. Frame reception, parsing of the control frame and the FIFO itself are outside this block.

Top module: `link_pause_gate`

## Requirements
- R1: After a synchronous active-low reset the block is running: `pause_status` is 0 and `tx_rd_allow` is 1. `tx_rd_allow` is always the inverse of `pause_status`.
- R2: A request (`pause_req`=1) with non-zero `pause_quanta` while running and `tx_busy`=0 sets `pause_status` to 1 in the cycle after the request edge.
- R3: A request with non-zero quanta while running and `tx_busy`=1 keeps `pause_status` at 0 while `tx_busy` stays 1. `pause_status` becomes 1 in the cycle after the first edge that samples `tx_busy`=0.
- R4: The timer holds its value unless paused. Ticks that arrive while running or while waiting for the frame to end have no effect on the pause length.
- R5: Once paused with quanta Q, and with no new request, `pause_status` falls to 0 in the cycle after the edge that samples the Q-th tick. This holds for Q from 1 to 65535.
- R6: A request with non-zero quanta while paused reloads the timer with that quanta. The pause then lasts that many further ticks.
- R7: A request with quanta 0 while paused ends the pause. `pause_status` is 0 in the next cycle.
- R8: A request with quanta 0 while waiting for the frame to end cancels the pending pause. No pause follows when `tx_busy` later falls.
- R9: A request with quanta 0 while running has no effect. `pause_status` stays 0.
- R10: If a request and a tick arrive in the same cycle while paused, the request wins. The timer takes the new quanta and is not decremented that cycle.
- R11: A request with non-zero quanta while waiting for the frame to end replaces the stored quanta. The pause that follows lasts for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pause_req | input | 1 | One-cycle strobe: a link pause request was received |
| pause_quanta | input | 16 | Quanta carried by the request, valid with `pause_req` |
| tx_busy | input | 1 | A frame is being transmitted |
| quanta_tick | input | 1 | One pulse per pause quantum |
| tx_rd_allow | output | 1 | 1 allows the transmitter to read the next frame from the FIFO |
| pause_status | output | 1 | 1 while the transmitter is in the pause state |

## Verification
The bench checks each corner case against the error a faulty design would make there:
- Ticks during the wait for the frame to end: a design that counts them would end the pause too early.
- A request and a tick in the same cycle: a design that lets the tick win would shorten the pause by one.
- Quanta zero during the wait: a design that ignores it would pause anyway once the frame ends.
- Quanta zero while idle: a design that acts on it would lock the transmitter.
- Quanta of 65535: a design with an off-by-one in the last-count test would release the gate one tick early or late. So would a design with a narrow counter.

// File: rtl/link_pause_pkg.sv
// Package: shared types for the link pause transmit gate.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package link_pause_pkg;

    // Control states: free running, waiting for end of frame, paused.
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WAIT_EOF = 2'd1,
        ST_PAUSED   = 2'd2
    } pause_state_e;

endpackage

// File: rtl/link_pause_timer.sv
// Module: pause quanta countdown timer.
// Loads a quanta value on request and decrements by one when told to.
// Assumes the controller never asks for a decrement at a count of zero.
module link_pause_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          dec,
    output logic          last,
    output logic [QW-1:0] count
);

    localparam logic [QW-1:0] ONE = QW'(1);

    // Counter register: a load has priority over a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - ONE;
        end
    end

    // One step remains before expiry.
    assign last = (count == ONE);

    // R4: with neither load nor decrement, the count keeps its value.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(count));

    // R5: a decrement is never requested on an empty timer.
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0));

endmodule

// File: rtl/link_pause_fsm.sv
// Module: pause state controller.
// Decides when the transmitter enters and leaves the pause state.
// Assumes pause_req is a single-cycle strobe and that tx_busy stays high
// for the whole of a frame that is in flight.
module link_pause_fsm
    import link_pause_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pause_req,
    input  logic [QW-1:0] pause_quanta,
    input  logic          tx_busy,
    input  logic          quanta_tick,
    input  logic          timer_last,
    output pause_state_e  state,
    output logic          timer_load,
    output logic          timer_dec
);

    pause_state_e nxt;
    logic         q_nz;

    assign q_nz = (pause_quanta != '0);

    // Next-state selection from the current state and the inputs.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (pause_req && q_nz) begin
                    nxt = tx_busy ? ST_WAIT_EOF : ST_PAUSED;
                end
            end
            ST_WAIT_EOF: begin
                if (pause_req && !q_nz) begin
                    nxt = ST_RUN;
                end else if (!tx_busy) begin
                    nxt = ST_PAUSED;
                end
            end
            ST_PAUSED: begin
                if (pause_req) begin
                    nxt = q_nz ? ST_PAUSED : ST_RUN;
                end else if (quanta_tick && timer_last) begin
                    nxt = ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    // Timer controls: every request loads; ticks count only while paused.
    assign timer_load = pause_req;
    assign timer_dec  = (state == ST_PAUSED) && quanta_tick && !pause_req;

    // R2: an idle transmitter pauses right away.
    p_idle_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pause_req && q_nz && !tx_busy) |=> (state == ST_PAUSED));

    // R3: a busy transmitter first finishes its frame.
    p_busy_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pause_req && q_nz && tx_busy) |=> (state == ST_WAIT_EOF));

    // R5: the pause ends on the tick that empties the timer.
    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSED && !pause_req && quanta_tick && timer_last) |=> (state == ST_RUN));

    // R7: quanta zero ends a running pause.
    p_zero_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSED && pause_req && !q_nz) |=> (state == ST_RUN));

    // R8: quanta zero cancels a pending pause.
    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_EOF && pause_req && !q_nz) |=> (state == ST_RUN));

    // R9: quanta zero while running changes nothing.
    p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pause_req && !q_nz) |=> (state == ST_RUN));

endmodule

// File: rtl/link_pause_gate.sv
// Module: link pause transmit gate (top).
// Holds the transmit FIFO read gate closed for the requested number of
// pause quanta. The pause starts only after any frame in flight completes.
// Assumes quanta_tick is a single-cycle pulse per quantum.
module link_pause_gate
    import link_pause_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pause_req,
    input  logic [QW-1:0] pause_quanta,
    input  logic          tx_busy,
    input  logic          quanta_tick,
    output logic          tx_rd_allow,
    output logic          pause_status
);

    pause_state_e  state;
    logic          t_load;
    logic          t_dec;
    logic          t_last;
    logic [QW-1:0] t_count;

    link_pause_fsm #(.QW(QW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pause_req    (pause_req),
        .pause_quanta (pause_quanta),
        .tx_busy      (tx_busy),
        .quanta_tick  (quanta_tick),
        .timer_last   (t_last),
        .state        (state),
        .timer_load   (t_load),
        .timer_dec    (t_dec)
    );

    link_pause_timer #(.QW(QW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (pause_quanta),
        .dec      (t_dec),
        .last     (t_last),
        .count    (t_count)
    );

    // Output decode: status is the pause state itself, the gate is its inverse.
    assign pause_status = (state == ST_PAUSED);
    assign tx_rd_allow  = !pause_status;

    // R6/R10: a request while paused always lands the new quanta in the timer.
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSED && pause_req && pause_quanta != '0)
            |=> (t_count == $past(pause_quanta)));

    // R4: the timer holds its value while waiting for the frame to end.
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_EOF && !pause_req) |=> $stable(t_count));

endmodule

// File: tb/link_pause_gate_tb.sv
module link_pause_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_req = 1'b0;
    logic [15:0] pause_quanta = '0;
    logic        tx_busy = 1'b0;
    logic        quanta_tick = 1'b0;
    logic        tx_rd_allow;
    logic        pause_status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    link_pause_gate u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pause_req    (pause_req),
        .pause_quanta (pause_quanta),
        .tx_busy      (tx_busy),
        .quanta_tick  (quanta_tick),
        .tx_rd_allow  (tx_rd_allow),
        .pause_status (pause_status)
    );

    typedef struct packed {
        logic        req;
        logic [15:0] q;
        logic        busy;
        logic        tick;
        logic        exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'd3, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 idle entry
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b1, 4'd5},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 third tick ends
        '{1'b1, 16'd2, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 wait for frame end
        '{1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 tick ignored
        '{1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 frame done
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd4},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 full two ticks
        '{1'b1, 16'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 16'd2, 1'b0, 1'b0, 1'b1, 4'd6},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd6},
        '{1'b1, 16'd3, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 reload
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd6},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd6},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd6},
        '{1'b1, 16'd5, 1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 16'd0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 cancel
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b1, 16'd4, 1'b0, 1'b0, 1'b1, 4'd7},
        '{1'b1, 16'd0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{1'b1, 16'd2, 1'b0, 1'b0, 1'b1, 4'd10},
        '{1'b1, 16'd3, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 request beats tick
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd10},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd10},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd10},
        '{1'b1, 16'd4, 1'b1, 1'b0, 1'b0, 4'd11},
        '{1'b1, 16'd1, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 replace
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b1, 4'd11},
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd11}
    };

    task automatic check(input string tag, input logic exp_st);
        checks++;
        if (pause_status !== exp_st || tx_rd_allow !== !exp_st) begin
            errors++;
            $display("FAIL %s: status=%b allow=%b expected status=%b allow=%b",
                     tag, pause_status, tx_rd_allow, exp_st, !exp_st);
        end
    endtask

    // Drive at the falling edge, sample 2 ns after the next rising edge.
    task automatic step(input logic rq, input logic [15:0] q,
                        input logic bz, input logic tk);
        @(negedge clk);
        pause_req    = rq;
        pause_quanta = q;
        tx_busy      = bz;
        quanta_tick  = tk;
        @(posedge clk);
        #2;
        pause_req   = 1'b0;
        quanta_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].req, VEC[i].q, VEC[i].busy, VEC[i].tick);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].exp);
        end

        // R5: one-quantum pause
        step(1'b1, 16'd1, 1'b0, 1'b0);
        check("R5 q1 entry", 1'b1);
        step(1'b0, 16'd0, 1'b0, 1'b1);
        check("R5 q1 exit", 1'b0);

        // R5: largest quanta, tick every cycle
        step(1'b1, 16'hFFFF, 1'b0, 1'b0);
        check("R5 max entry", 1'b1);
        for (int k = 0; k < 65534; k++) begin
            step(1'b0, 16'd0, 1'b0, 1'b1);
        end
        check("R5 max one left", 1'b1);
        step(1'b0, 16'd0, 1'b0, 1'b1);
        check("R5 max exit", 1'b0);

        // R1: reset in the middle of a pause returns to running
        step(1'b1, 16'd9, 1'b0, 1'b0);
        check("R1 pre-reset pause", 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1 reset mid pause", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 16'd0, 1'b0, 1'b1);
        check("R1 after reset", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule